// File: doc/BRIEF.md
# PHY Management Register Model

This block models the host side of a PHY management port together with a small PHY register file behind it. Software writes a command word naming a PHY address, a register number and a direction. One clock later the command runs against an embedded register set. That set holds control, status, two identifier words, advertisement and link-partner ability.

A separate data register carries the value for a write. It also receives the result of a read. Nothing is shifted out serially: each command completes in a single internal step. A configured address strap selects which PHY address the model answers to. A link input keeps the link-up bit of the status word current at all times.

Top module: `mgmt_phy_regs`

## Requirements
- R1: A host write to the command register (`host_sel`=0) stores the written word with bit 0 (busy) forced to zero. `cmd_rdata` shows the stored word from the next cycle onward. The command fields are: PHY address in [15:12], register number in [7:4], and bit 1 set for a write or clear for a read.
- R2: After reset, `cmd_rdata` and `data_rdata` are zero, control register 0 reads 0x3100 and advertisement register 4 reads 0x0000.
- R3: A command whose PHY address differs from `cfg_phy_addr` changes no PHY register and leaves `data_rdata` unchanged.
- R4: A read command written at clock edge N loads the register value, zero-extended to 32 bits, into `data_rdata` at edge N+1. Before edge N+1, `data_rdata` still holds its old value.
- R5: A write command to register 0 with data bit 15 clear stores data[15:0] with bits 15 and 9 cleared.
- R6: A write command to register 0 with data bit 15 set returns control to 0x3100 and advertisement to 0x0000. The link bit still follows `link_in`.
- R7: Register 1 reads 0xFE28 with bit 2 ORed in. Bit 2 equals `link_in` as sampled one cycle earlier, and tracks it without any command.
- R8: Registers 2, 3 and 5 read 0x0044, 0x1400 and 0x0DE0. Write commands to registers 1, 2, 3 and 5 change nothing.
- R9: Register 4 stores data[15:0] on a write command and returns it on a read.
- R10: Register numbers 6 to 15 read as zero, and write commands to them change nothing.
- R11: A host write to the data register (`host_sel`=1) at the same edge as a read completion wins, so `data_rdata` takes the host value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = command register, 1 = data register |
| host_wdata | input | 32 | Host write value |
| cfg_phy_addr | input | 4 | PHY address this model answers to |
| link_in | input | 1 | Link-up indication |
| cmd_rdata | output | 32 | Current command register |
| data_rdata | output | 32 | Current data register |

## Verification
All PHY state is hidden behind the data register, so a corrupted control or advertisement value shows up only on the next read command. It appears on `data_rdata` exactly one edge after that command is written. The bench therefore reads back every register after each write and after each address-mismatch attempt. A stale or wrongly masked field becomes visible within two cycles of the command that exposes it. A timing slip in the read path shows as the old value still present at the sampling point after edge N+1.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int CMD_W   = 32;
  localparam int PADDR_W = 4;
  localparam int REGN_W  = 4;
  localparam int PREG_W  = 16;

  // field positions the decoder depends on
  localparam int PADDR_LSB = 12;
  localparam int REGN_LSB  = 4;
  localparam int DIR_BIT   = 1;
  localparam int BUSY_BIT  = 0;

  localparam logic [REGN_W-1:0] RN_CTL  = 4'd0;
  localparam logic [REGN_W-1:0] RN_STAT = 4'd1;
  localparam logic [REGN_W-1:0] RN_IDH  = 4'd2;
  localparam logic [REGN_W-1:0] RN_IDL  = 4'd3;
  localparam logic [REGN_W-1:0] RN_ADV  = 4'd4;
  localparam logic [REGN_W-1:0] RN_LPA  = 4'd5;

  localparam logic [PREG_W-1:0] CTL_RESET  = 16'h3100;
  localparam logic [PREG_W-1:0] CTL_KEEP   = 16'h7DFF;
  localparam int                CTL_SRST   = 15;
  localparam logic [PREG_W-1:0] STAT_FIXED = 16'hFE28;
  localparam int                STAT_LINK  = 2;
  localparam logic [PREG_W-1:0] ID_HIGH    = 16'h0044;
  localparam logic [PREG_W-1:0] ID_LOW     = 16'h1400;
  localparam logic [PREG_W-1:0] LPA_WORD   = 16'h0DE0;

  typedef struct packed {
    logic [PADDR_W-1:0] paddr;
    logic [REGN_W-1:0]  regn;
    logic               is_wr;
  } cmd_t;

  function automatic cmd_t cmd_fields(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.paddr = w[PADDR_LSB +: PADDR_W];
    c.regn  = w[REGN_LSB +: REGN_W];
    c.is_wr = w[DIR_BIT];
    return c;
  endfunction

  function automatic logic [PREG_W-1:0] ctl_store(input logic [PREG_W-1:0] d);
    return d & CTL_KEEP;
  endfunction

  function automatic logic [PREG_W-1:0] status_word(input logic link);
    logic [PREG_W-1:0] s;
    s = STAT_FIXED;
    s[STAT_LINK] = link;
    return s;
  endfunction
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
  import mgmt_phy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [CMD_W-1:0]   wdata,
  input  logic [PADDR_W-1:0] cfg_addr,
  output logic [CMD_W-1:0]   cmd_q,
  output logic               exec_go,
  output logic               exec_miss,
  output logic               exec_wr,
  output logic [REGN_W-1:0]  exec_reg
);
  logic pend_q;
  cmd_t fields;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= cmd_we;
      if (cmd_we) begin
        cmd_q           <= wdata;
        cmd_q[BUSY_BIT] <= 1'b0;
      end
    end
  end

  always_comb begin
    fields    = cmd_fields(cmd_q);
    exec_go   = pend_q && (fields.paddr == cfg_addr);
    exec_miss = pend_q && (fields.paddr != cfg_addr);
    exec_wr   = fields.is_wr;
    exec_reg  = fields.regn;
  end

  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (cmd_q == ($past(wdata) & ~32'd1))); // R1
endmodule

// File: rtl/mgmt_phy_file.sv
module mgmt_phy_file
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_go,
  input  logic              exec_wr,
  input  logic [REGN_W-1:0] exec_reg,
  input  logic [PREG_W-1:0] wr_val,
  input  logic              link_in,
  output logic [PREG_W-1:0] rd_val
);
  logic [PREG_W-1:0] ctl_q, adv_q;
  logic              link_q;
  logic              wr_ctl, wr_adv, soft_rst;

  always_comb begin
    wr_ctl   = exec_go && exec_wr && (exec_reg == RN_CTL);
    wr_adv   = exec_go && exec_wr && (exec_reg == RN_ADV);
    soft_rst = wr_ctl && wr_val[CTL_SRST];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      adv_q  <= '0;
      link_q <= 1'b0;
    end else begin
      link_q <= link_in;
      if (soft_rst) begin
        ctl_q <= CTL_RESET;
        adv_q <= '0;
      end else if (wr_ctl) begin
        ctl_q <= ctl_store(wr_val);
      end else if (wr_adv) begin
        adv_q <= wr_val;
      end
    end
  end

  always_comb begin
    case (exec_reg)
      RN_CTL:  rd_val = ctl_q;
      RN_STAT: rd_val = status_word(link_q);
      RN_IDH:  rd_val = ID_HIGH;
      RN_IDL:  rd_val = ID_LOW;
      RN_ADV:  rd_val = adv_q;
      RN_LPA:  rd_val = LPA_WORD;
      default: rd_val = '0;
    endcase
  end

  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wr_val[CTL_SRST]) |=> (ctl_q == ($past(wr_val) & 16'h7DFF))); // R5
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl_q == 16'h3100 && adv_q == 16'h0000)); // R6
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && exec_wr && exec_reg != RN_CTL && exec_reg != RN_ADV)
      |=> ($stable(ctl_q) && $stable(adv_q))); // R8
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_phy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic               host_sel,
  input  logic [CMD_W-1:0]   host_wdata,
  input  logic [PADDR_W-1:0] cfg_phy_addr,
  input  logic               link_in,
  output logic [CMD_W-1:0]   cmd_rdata,
  output logic [CMD_W-1:0]   data_rdata
);
  logic              cmd_we, data_we;
  logic              exec_go, exec_miss, exec_wr, rd_done;
  logic [REGN_W-1:0] exec_reg;
  logic [PREG_W-1:0] rd_val;
  logic [CMD_W-1:0]  data_q;

  assign cmd_we  = host_we && !host_sel;
  assign data_we = host_we && host_sel;
  assign rd_done = exec_go && !exec_wr;

  mgmt_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .wdata(host_wdata),
    .cfg_addr(cfg_phy_addr), .cmd_q(cmd_rdata), .exec_go(exec_go),
    .exec_miss(exec_miss), .exec_wr(exec_wr), .exec_reg(exec_reg)
  );

  mgmt_phy_file u_file (
    .clk(clk), .rst_n(rst_n), .exec_go(exec_go), .exec_wr(exec_wr),
    .exec_reg(exec_reg), .wr_val(data_q[PREG_W-1:0]), .link_in(link_in),
    .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= host_wdata;
    else if (rd_done) data_q <= {{(CMD_W-PREG_W){1'b0}}, rd_val};
  end

  assign data_rdata = data_q;

  AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !data_we) |=> (data_rdata == {16'h0, $past(rd_val)})); // R4
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_miss && !data_we) |=> $stable(data_rdata)); // R3
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (data_rdata == $past(host_wdata))); // R11
endmodule

// File: tb/mgmt_phy_regs_bench.sv
module mgmt_phy_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  cfg_phy_addr = 4'd5;
  logic        link_in = 1'b0;
  logic [31:0] cmd_rdata, data_rdata;
  int checks = 0, errors = 0;

  logic [15:0] m_ctl, m_adv;

  always #5 clk = ~clk;

  mgmt_phy_regs u_mgmt_phy_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .cfg_phy_addr(cfg_phy_addr), .link_in(link_in),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata)
  );

  function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] r,
                                     input logic w);
    return {16'h0, a, 4'h0, r, 2'b00, w, 1'b0};
  endfunction

  function automatic logic [15:0] expect_reg(input logic [3:0] r, input logic lk,
                                             input logic [15:0] c, input logic [15:0] a);
    case (r)
      4'd0: return c;
      4'd1: return 16'h8000 + 16'h4000 + 16'h2000 + 16'h1000 + 16'h0800 +
                   16'h0400 + 16'h0200 + 16'h0020 + 16'h0008 + (lk ? 16'h0004 : 16'h0);
      4'd2: return 16'h0044;
      4'd3: return 16'h1400;
      4'd4: return a;
      4'd5: return (16'h1 << 5) | (16'h1 << 6) | (16'h1 << 7) | (16'h1 << 8) |
                   (16'h1 << 10) | (16'h1 << 11);
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic phy_read(input logic [3:0] a, input logic [3:0] r, output logic [31:0] v);
    host_wr(1'b0, mk(a, r, 1'b0));
    @(negedge clk);
    v = data_rdata;
  endtask

  task automatic phy_write(input logic [3:0] a, input logic [3:0] r, input logic [15:0] v);
    host_wr(1'b1, {16'h0, v});
    host_wr(1'b0, mk(a, r, 1'b1));
    @(negedge clk);
  endtask

  task automatic read_all(input string req);
    logic [31:0] v;
    for (int r = 0; r < 16; r++) begin
      phy_read(4'd5, 4'(r), v);
      chk(req, v, {16'h0, expect_reg(4'(r), link_in, m_ctl, m_adv)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] vals [5];
    vals[0] = 16'h7FFF; vals[1] = 16'h0200; vals[2] = 16'h1234;
    vals[3] = 16'h4140; vals[4] = 16'h0000;
    m_ctl = 16'h3100; m_adv = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 cmd", cmd_rdata, 32'h0);
    chk("R2 data", data_rdata, 32'h0);
    phy_read(4'd5, 4'd0, v); chk("R2 ctl", v, 32'h3100);
    phy_read(4'd5, 4'd4, v); chk("R2 adv", v, 32'h0);

    // R1: busy bit stored as zero
    host_wr(1'b0, 32'h0000F0F3);
    chk("R1", cmd_rdata, 32'h0000F0F2);
    host_wr(1'b0, 32'hA5A55A5B);
    chk("R1", cmd_rdata, 32'hA5A55A5A);
    @(negedge clk);

    // R7: link tracks without commands
    link_in = 1'b1; @(negedge clk); @(negedge clk);
    phy_read(4'd5, 4'd1, v); chk("R7 up", v, 32'h0000FE2C);
    link_in = 1'b0; @(negedge clk);
    phy_read(4'd5, 4'd1, v); chk("R7 down", v, 32'h0000FE28);
    link_in = 1'b1;

    // R8 R10: full register sweep
    read_all("R8/R10 sweep");

    // R4: timing of read result
    host_wr(1'b1, 32'hDEADBEEF);
    @(negedge clk);
    host_we = 1'b1; host_sel = 1'b0; host_wdata = mk(4'd5, 4'd2, 1'b0);
    @(negedge clk);
    host_we = 1'b0;
    chk("R4 before", data_rdata, 32'hDEADBEEF);
    @(negedge clk);
    chk("R4 after", data_rdata, 32'h00000044);

    // R5: control write masking
    foreach (vals[i]) begin
      phy_write(4'd5, 4'd0, vals[i]);
      m_ctl = vals[i] & ~(16'h8000 | 16'h0200);
      phy_read(4'd5, 4'd0, v); chk("R5", v, {16'h0, m_ctl});
    end

    // R9: advertisement read/write
    for (int k = 0; k < 4; k++) begin
      m_adv = 16'h1111 * 16'(k + 3);
      phy_write(4'd5, 4'd4, m_adv);
      phy_read(4'd5, 4'd4, v); chk("R9", v, {16'h0, m_adv});
    end

    // R8 R10: writes to read-only and unused numbers ignored
    for (int r = 1; r < 16; r++) begin
      if (r != 4) phy_write(4'd5, 4'(r), 16'hFFFF);
    end
    read_all("R8/R10 after writes");

    // R3: mismatched addresses have no effect
    for (int a = 0; a < 16; a++) begin
      if (a != 5) begin
        phy_write(4'(a), 4'd4, 16'h5555);
        phy_write(4'(a), 4'd0, 16'h8000);
        host_wr(1'b1, 32'h0BADF00D);
        phy_read(4'(a), 4'd2, v); chk("R3 data", v, 32'h0BADF00D);
      end
    end
    phy_read(4'd5, 4'd4, v); chk("R3 adv", v, {16'h0, m_adv});
    phy_read(4'd5, 4'd0, v); chk("R3 ctl", v, {16'h0, m_ctl});

    // R6: soft reset
    phy_write(4'd5, 4'd4, 16'hABCD);
    phy_write(4'd5, 4'd0, 16'h8000 | 16'h0140);
    m_ctl = 16'h3100; m_adv = 16'h0;
    phy_read(4'd5, 4'd0, v); chk("R6 ctl", v, 32'h3100);
    phy_read(4'd5, 4'd4, v); chk("R6 adv", v, 32'h0);
    phy_read(4'd5, 4'd1, v); chk("R6 link kept", v, 32'h0000FE2C);

    // R11: host data write collides with read completion
    @(negedge clk);
    host_we = 1'b1; host_sel = 1'b0; host_wdata = mk(4'd5, 4'd3, 1'b0);
    @(negedge clk);
    host_sel = 1'b1; host_wdata = 32'h12345678;
    @(negedge clk);
    host_we = 1'b0;
    chk("R11", data_rdata, 32'h12345678);
    @(negedge clk);
    chk("R11 hold", data_rdata, 32'h12345678);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule